// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the system reset of a chip from a small set of supervisory inputs. The inputs are a digital under-voltage flag for the main supply, a raw active-low manual-reset button, and one configuration bit that picks a short or a long stretch period. It drives a reset in both polarities, an active-low early-warning low-line flag, and a flag that tells the serial interface to ignore traffic while reset is asserted.

One cycle-accurate stretch counter serves three cases: power-up, recovery from brownout, and release of the debounced manual reset. Each time every hold condition clears, reset stays asserted for the full selected period. If a hold condition returns during the stretch, the count starts again from the full value. The low-line flag tracks the under-voltage flag combinationally. Reset follows a fixed number of cycles later, so a downstream consumer sees the early warning before the reset edge.

All periods are parameters counted in clock cycles, derived from a cycles-per-millisecond figure. The defaults are 150 ms and 800 ms stretch, 20 ms debounce, and a 25-cycle lead, which is 250 ns at 100 MHz.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rstN` is low, `resetN` is 0. Let E0 be the first rising edge at which `rstN` is high, `lowSupply` is 0 and manual reset is not held. `resetN` goes to 1 after rising edge E0+P, where P is the stretch period in cycles.
- R2: The stretch period P is SHORT_MS*CLK_PER_MS cycles when `longPeriod` is 0 and LONG_MS*CLK_PER_MS cycles when it is 1. The bit is sampled at the edge where the stretch starts.
- R3: Take a rising edge at which reset is released and `lowSupply` is 1. `resetN` goes to 0 after the LEAD_CYCLES-th following edge. Reset then stays asserted while `lowSupply` is 1. Once `lowSupply` is sampled 0 again, the rule of R1 applies from that edge.
- R4: If `lowSupply` is sampled 1 at any edge during a stretch, `resetN` stays 0. The next stretch runs for the full P cycles, counted from the edge where `lowSupply` is next sampled 0.
- R5: The manual-reset input (`mrRawN`, 0 = pressed) is accepted only after it has been sampled at one new level on DB consecutive rising edges, where DB = DEBOUNCE_MS*CLK_PER_MS. A press shorter than DB edges has no effect on `resetN`.
- R6: Once a press is accepted, `resetN` goes to 0 one edge later, that is DB+1 edges after the press. After release, `resetN` returns to 1 DB+1+P edges after the release.
- R7: `lowLineN` equals the inverse of `lowSupply` with no clock delay, in both directions.
- R8: `resetHi` is always the inverse of `resetN`.
- R9: `blockSerial` is 1 exactly when `resetN` is 0.
- R10: Between the rise of `lowSupply` in the released state and the assertion of reset, `lowLineN` is 0 while `resetN` is still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock with known cycles per millisecond |
| rstN | input | 1 | Power-on reset of the block, active low |
| lowSupply | input | 1 | Main supply below its trip point, active high |
| mrRawN | input | 1 | Raw manual reset, active low, undebounced |
| longPeriod | input | 1 | Stretch select: 0 short, 1 long |
| resetN | output | 1 | System reset, active low |
| resetHi | output | 1 | System reset, active high |
| lowLineN | output | 1 | Early low-supply warning, active low |
| blockSerial | output | 1 | Serial interface must ignore transactions |

## Verification
A reduced configuration runs power-up and brownout recovery with both period settings. This separates the short and long counts and confirms that the same counter serves both hold causes. Supply dips of one cycle land at the first and last cycle of a stretch, which tells a full reload apart from a resume or a partial count. Manual-reset pulses are swept over every width below the debounce length and then held long. This pins the exact acceptance edge and the release-to-reset delay. The brownout entry is checked edge by edge, so the low-line lead and its exact length are measured directly.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2,
    ST_LEAD    = 2'd3
  } supvState_t;

  typedef struct packed {
    logic loadStretch;
    logic runStretch;
    logic loadLead;
    logic runLead;
  } supvStrobes_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int CLK_PER_MS  = 100000,
  parameter int SHORT_MS    = 150,
  parameter int LONG_MS     = 800,
  parameter int DEBOUNCE_MS = 20,
  parameter int LEAD_CYCLES = 25
) (
  input  logic         clk,
  input  logic         rstN,
  input  supvStrobes_t strobes,
  input  logic         longPeriod,
  input  logic         mrRawN,
  output logic         stretchDone,
  output logic         leadDone,
  output logic         mrHeld
);

  localparam int SHORT_CYC = SHORT_MS * CLK_PER_MS;
  localparam int LONG_CYC  = LONG_MS * CLK_PER_MS;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam int LEAD_W    = $clog2(LEAD_CYCLES + 1);
  localparam int DB_CYC    = DEBOUNCE_MS * CLK_PER_MS;
  localparam int DB_W      = $clog2(DB_CYC + 1);

  localparam logic [CNT_W-1:0]  SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0]  LONG_LOAD  = CNT_W'(LONG_CYC - 1);
  localparam logic [LEAD_W-1:0] LEAD_LOAD  = LEAD_W'(LEAD_CYCLES - 1);

  logic [CNT_W-1:0]  stretchCnt;
  logic [LEAD_W-1:0] leadCnt;
  logic              mrStable;

  // Stretch counter: loaded with the full period, counts down to zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stretchCnt <= '0;
    end else if (strobes.loadStretch) begin
      stretchCnt <= longPeriod ? LONG_LOAD : SHORT_LOAD;
    end else if (strobes.runStretch && (stretchCnt != '0)) begin
      stretchCnt <= stretchCnt - 1'b1;
    end
  end

  assign stretchDone = (stretchCnt == '0);

  // R4: between loads the stretch count never grows
  assert_stretch_monotonic_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadStretch |=> (stretchCnt <= $past(stretchCnt)));

  // Lead counter: spacing between low-line and reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leadCnt <= '0;
    end else if (strobes.loadLead) begin
      leadCnt <= LEAD_LOAD;
    end else if (strobes.runLead && (leadCnt != '0)) begin
      leadCnt <= leadCnt - 1'b1;
    end
  end

  assign leadDone = (leadCnt == '0);

  // R10: the lead count is never reloaded while it is still running down
  assert_lead_no_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.runLead && !leadDone) |-> !strobes.loadLead);

  // Manual-reset debounce
  generate
    if (DB_CYC > 1) begin : g_debounce
      logic [DB_W-1:0] dbCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dbCnt    <= '0;
          mrStable <= 1'b1;
        end else if (mrRawN == mrStable) begin
          dbCnt <= '0;
        end else if (dbCnt == DB_W'(DB_CYC - 1)) begin
          dbCnt    <= '0;
          mrStable <= mrRawN;
        end else begin
          dbCnt <= dbCnt + 1'b1;
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mrStable <= 1'b1;
        end else begin
          mrStable <= mrRawN;
        end
      end
    end
  endgenerate

  // R5: the accepted level only moves toward a level the raw input showed
  assert_debounce_follows_raw_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mrStable) |-> ($past(mrRawN) == mrStable));

  assign mrHeld = !mrStable;

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lowSupply,
  input  logic         mrHeld,
  input  logic         stretchDone,
  input  logic         leadDone,
  output supvStrobes_t strobes,
  output logic         resetAsserted
);

  supvState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_HOLD: begin
        if (!lowSupply && !mrHeld) begin
          stateD              = ST_STRETCH;
          strobes.loadStretch = 1'b1;
        end
      end
      ST_STRETCH: begin
        if (lowSupply || mrHeld) begin
          stateD = ST_HOLD;
        end else if (stretchDone) begin
          stateD = ST_RUN;
        end else begin
          strobes.runStretch = 1'b1;
        end
      end
      ST_RUN: begin
        if (mrHeld) begin
          stateD = ST_HOLD;
        end else if (lowSupply) begin
          stateD           = ST_LEAD;
          strobes.loadLead = 1'b1;
        end
      end
      ST_LEAD: begin
        if (leadDone) begin
          stateD = ST_HOLD;
        end else begin
          strobes.runLead = 1'b1;
        end
      end
      default: stateD = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_HOLD;
    else       stateQ <= stateD;
  end

  assign resetAsserted = (stateQ == ST_HOLD) || (stateQ == ST_STRETCH);

  // R1: release only after the stretch count has run out
  assert_release_after_stretch_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && $past(stateQ) == ST_STRETCH) |-> $past(stretchDone));

  // R6: a direct drop from released to hold needs an accepted manual press
  assert_direct_hold_needs_press_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && $past(stateQ) == ST_RUN) |-> $past(mrHeld));

  // R4: a dip during the stretch aborts it
  assert_dip_aborts_stretch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STRETCH && lowSupply) |=> (stateQ == ST_HOLD));

  // R3: under-voltage while released starts the lead window
  assert_lowsupply_starts_lead_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && lowSupply && !mrHeld) |=> (stateQ == ST_LEAD));

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int CLK_PER_MS  = 100000,
  parameter int SHORT_MS    = 150,
  parameter int LONG_MS     = 800,
  parameter int DEBOUNCE_MS = 20,
  parameter int LEAD_CYCLES = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowSupply,
  input  logic mrRawN,
  input  logic longPeriod,
  output logic resetN,
  output logic resetHi,
  output logic lowLineN,
  output logic blockSerial
);

  supvStrobes_t strobes;
  logic stretchDone, leadDone, mrHeld, resetAsserted;

  supv_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .lowSupply     (lowSupply),
    .mrHeld        (mrHeld),
    .stretchDone   (stretchDone),
    .leadDone      (leadDone),
    .strobes       (strobes),
    .resetAsserted (resetAsserted)
  );

  supv_datapath #(
    .CLK_PER_MS  (CLK_PER_MS),
    .SHORT_MS    (SHORT_MS),
    .LONG_MS     (LONG_MS),
    .DEBOUNCE_MS (DEBOUNCE_MS),
    .LEAD_CYCLES (LEAD_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .longPeriod  (longPeriod),
    .mrRawN      (mrRawN),
    .stretchDone (stretchDone),
    .leadDone    (leadDone),
    .mrHeld      (mrHeld)
  );

  assign resetN      = !resetAsserted;
  assign resetHi     = resetAsserted;
  assign blockSerial = resetAsserted;
  assign lowLineN    = !lowSupply;

  // R10: a reset edge caused by supply loss is preceded by low-line
  assert_lowline_leads_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(resetN) && !resetN && !$past(mrHeld)) |-> $past(!lowLineN));

endmodule

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb;

  localparam int CPM  = 10;
  localparam int SMS  = 3;
  localparam int LMS  = 8;
  localparam int DMS  = 2;
  localparam int LEAD = 5;
  localparam int P0   = SMS * CPM;
  localparam int P1   = LMS * CPM;
  localparam int DB   = DMS * CPM;
  localparam int CAP  = 4 * P1 + 100;

  logic clk = 1'b0;
  logic rstN, lowSupply, mrRawN, longPeriod;
  logic resetN, resetHi, lowLineN, blockSerial;

  int checks = 0;
  int failures = 0;
  int invBad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  supv_reset_gen #(
    .CLK_PER_MS (CPM), .SHORT_MS (SMS), .LONG_MS (LMS),
    .DEBOUNCE_MS (DMS), .LEAD_CYCLES (LEAD)
  ) u_dut (
    .clk (clk), .rstN (rstN), .lowSupply (lowSupply), .mrRawN (mrRawN),
    .longPeriod (longPeriod), .resetN (resetN), .resetHi (resetHi),
    .lowLineN (lowLineN), .blockSerial (blockSerial)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (resetHi != !resetN || blockSerial != !resetN) invBad++;
    end
  endtask

  task automatic waitFor(input logic lvl, output int k);
    k = 0;
    do begin
      edges(1);
      k++;
    end while (resetN != lvl && k < CAP);
  endtask

  initial begin
    int k;
    int held;
    rstN = 1'b0; lowSupply = 1'b0; mrRawN = 1'b1; longPeriod = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state resetN", resetN, 0);
    chk("R8 reset state resetHi", resetHi, 1);
    chk("R9 reset state blockSerial", blockSerial, 1);
    chk("R7 reset state lowLineN", lowLineN, 1);

    for (int lp = 0; lp < 2; lp++) begin
      int per;
      per = (lp == 1) ? P1 : P0;
      longPeriod = lp[0];
      rstN = 1'b0;
      edges(3);
      rstN = 1'b1;
      waitFor(1'b1, k);
      chk($sformatf("R1 R2 power-up release edges lp=%0d", lp), k, per + 1);

      // brownout entry: lead window
      lowSupply = 1'b1;
      #1;
      chk("R7 lowLineN falls at once", lowLineN, 0);
      held = 0;
      for (int i = 0; i < LEAD; i++) begin
        edges(1);
        if (resetN == 1'b1 && lowLineN == 1'b0) held++;
      end
      chk("R10 low-line leads reset", held, LEAD);
      edges(1);
      chk("R3 reset asserts after lead", resetN, 0);
      edges(7);
      chk("R3 reset held during under-voltage", resetN, 0);
      lowSupply = 1'b0;
      #1;
      chk("R7 lowLineN rises at once", lowLineN, 1);
      waitFor(1'b1, k);
      chk($sformatf("R3 R2 brownout recovery edges lp=%0d", lp), k, per + 1);

      // dips inside the stretch at its first and last cycle
      for (int sel = 0; sel < 2; sel++) begin
        int d;
        d = (sel == 0) ? 1 : per - 1;
        lowSupply = 1'b1;
        edges(LEAD + 1);
        lowSupply = 1'b0;
        edges(d);
        chk($sformatf("R4 still held before dip d=%0d", d), resetN, 0);
        lowSupply = 1'b1;
        edges(1);
        lowSupply = 1'b0;
        waitFor(1'b1, k);
        chk($sformatf("R4 full reload after dip d=%0d lp=%0d", d, lp), k, per + 1);
      end
    end

    // manual reset: pulses shorter than the debounce length are ignored
    for (int w = 1; w < DB; w++) begin
      mrRawN = 1'b0;
      held = 0;
      for (int i = 0; i < w; i++) begin
        edges(1);
        if (resetN == 1'b1) held++;
      end
      mrRawN = 1'b1;
      for (int i = 0; i < DB + 3; i++) begin
        edges(1);
        if (resetN == 1'b1) held++;
      end
      chk($sformatf("R5 short press w=%0d ignored", w), held, w + DB + 3);
    end

    // accepted press and release
    mrRawN = 1'b0;
    waitFor(1'b0, k);
    chk("R5 R6 press to reset edges", k, DB + 1);
    edges(10);
    chk("R6 reset held while pressed", resetN, 0);
    mrRawN = 1'b1;
    waitFor(1'b1, k);
    chk("R6 release to deassert edges", k, DB + 1 + P1);

    chk("R8 R9 polarity and serial block consistent", invBad, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule